// File: doc/BRIEF.md
# Serial Debug Port Status Shifter

This block sits between an external debug tool and a CPU core. The tool moves one bit per shift strobe: it drives the serial input, and the port drives the serial output. Every frame the tool sends is answered, bit for bit, by a word the port shifts out at the same time. That outgoing word opens with a two-bit status code. For valid data the status is followed by data the CPU wrote. For any other status it is followed by a freeze flag, an active-low download flag and padding ones.

The port controls the pace of every transfer. While it is idle, a low serial output means the tool may start a frame, and a high output means it must wait. Outside debug mode the port becomes ready again as soon as a transfer finishes. In debug mode it becomes ready only after the CPU tries to read its instruction register or its data register. A long frame that arrives outside debug mode is answered with a sequencing error on the next transfer. Any frame received while that error is being shifted out is discarded.

Top module: `dbg_serial_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, the port returns to idle with ready deasserted, so `sdo` is 1 after that edge. `ir_new` and `dr_new` are 0, and no sequencing error is pending.
- R2: Outside debug mode, the idle port drives `sdo` low (ready) from the second clock after reset release, and again right after every transfer ends.
- R3: A frame starts only on a shift strobe with `sdi` = 1 while the port is idle and ready. Shift strobes while not ready are ignored, and `sdo` stays 1.
- R4: The status code is the first two bits out, MSB first: 01 sequencing error, 00 valid data, 10 CPU interrupt, 11 null. When more than one applies, priority follows that order, and data and interrupt count only in debug mode.
- R5: For statuses other than 00, the third bit out equals `dbg_mode`, the fourth equals the inverse of `dl_active`, and all later bits are 1.
- R6: For status 00, the 30 bits after the status are the value last written on `cpu_dr_wdata`, MSB first. That value is sent once only.
- R7: The input frame is a start bit, then a mode bit (1 = long), then a control bit (0 = instruction, 1 = data), then 30 payload bits (long) or 5 payload bits (short), MSB first. The port shifts out 32 bits for a long frame and 7 bits for a short frame. Each output bit is valid during the cycle of the strobe that takes in the matching input bit, starting with the mode bit.
- R8: Outside debug mode the status is only ever 01 or 11, even when CPU data is pending or `cpu_irq` is high.
- R9: A long frame received outside debug mode is not delivered to the CPU. Instead, the next transfer carries status 01.
- R10: A frame received while status 01 is being shifted out is discarded. It delivers nothing and raises no new sequencing error.
- R11: In debug mode, ready goes high only after a pulse on `cpu_ir_rd` or `cpu_dr_rd`. A pulse on `cpu_dr_wr` does not raise it.
- R12: In debug mode, a long frame with control bit 0 loads `ir_data` and pulses `ir_new` for one cycle. With control bit 1 it loads `dr_data` and pulses `dr_new`. Short frames deliver nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_mode | input | 1 | CPU is frozen in debug mode |
| dl_active | input | 1 | Download procedure running |
| cpu_irq | input | 1 | CPU interrupt condition to report |
| shift_en | input | 1 | One serial bit per cycle where high |
| sdi | input | 1 | Serial data from the tool |
| sdo | output | 1 | Serial data/ready to the tool |
| cpu_ir_rd | input | 1 | CPU instruction register read attempt |
| cpu_dr_rd | input | 1 | CPU data register read attempt |
| cpu_dr_wr | input | 1 | CPU data register write strobe |
| cpu_dr_wdata | input | 30 | Data the CPU writes for the tool |
| ir_data | output | 30 | Last instruction received |
| ir_new | output | 1 | Pulse: new instruction |
| dr_data | output | 30 | Last data word received |
| dr_new | output | 1 | Pulse: new data word |

## Verification
The bench sends two long frames in a row outside debug mode. A port that did not discard the frame received under an error would report a second sequencing error where null is expected. It enters debug mode with CPU data left pending from outside it: a port that leaked data or interrupt codes outside debug mode would send 00 early, and one that dropped the data would send null later. It pulses a register write and sends start bits while the port is not ready. A design that raised ready on the write, or accepted an early start, would shift every later word out of alignment with the scoreboard. Short frames in both modes check that the payload length follows the mode bit.

// File: rtl/dbgp_pkg.sv
// Shared types for the serial debug port.
// Assumes: status codes are sent MSB first and their values are fixed.
package dbgp_pkg;

    typedef enum logic [1:0] {
        ST_DATA   = 2'b00,
        ST_SEQERR = 2'b01,
        ST_IRQ    = 2'b10,
        ST_NULL   = 2'b11
    } dbgp_status_e;

    typedef enum logic [1:0] {
        RX_IDLE = 2'b00,
        RX_MODE = 2'b01,
        RX_BODY = 2'b10
    } dbgp_rx_state_e;

endpackage

// File: rtl/dbgp_frame_rx.sv
// Receive side of the debug port: spots the start bit, reads the mode bit
// and counts out the control and payload bits of the frame.
// Assumes: shift_en marks one serial bit per cycle; ready comes from the top.
module dbgp_frame_rx
    import dbgp_pkg::*;
#(
    parameter int LONG_PAY  = 30,
    parameter int SHORT_PAY = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic                sdi,
    input  logic                ready,
    output logic                start_acc,
    output logic                busy,
    output logic                last_shift,
    output logic                frame_long,
    output logic                frame_ctrl,
    output logic [LONG_PAY-1:0] frame_pay
);
    localparam int CNT_W = $clog2(LONG_PAY + 2);

    dbgp_rx_state_e      state_q;
    logic [CNT_W-1:0]    cnt_q;
    logic                long_q;
    logic [LONG_PAY-1:0] sr_q;
    logic [LONG_PAY:0]   full;

    assign full       = {sr_q, sdi};
    assign start_acc  = (state_q == RX_IDLE) && shift_en && sdi && ready;
    assign busy       = (state_q != RX_IDLE);
    assign last_shift = (state_q == RX_BODY) && shift_en && (cnt_q == CNT_W'(1));
    assign frame_long = long_q;
    assign frame_ctrl = long_q ? full[LONG_PAY] : full[SHORT_PAY];
    assign frame_pay  = long_q ? full[LONG_PAY-1:0]
                               : {{(LONG_PAY-SHORT_PAY){1'b0}}, full[SHORT_PAY-1:0]};

    // Frame sequencer: idle -> mode bit -> counted body bits -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            long_q  <= 1'b0;
            sr_q    <= '0;
        end else begin
            case (state_q)
                RX_IDLE: begin
                    if (start_acc) begin
                        state_q <= RX_MODE;
                        sr_q    <= '0;
                    end
                end
                RX_MODE: begin
                    if (shift_en) begin
                        long_q  <= sdi;
                        cnt_q   <= sdi ? CNT_W'(LONG_PAY + 1) : CNT_W'(SHORT_PAY + 1);
                        state_q <= RX_BODY;
                    end
                end
                RX_BODY: begin
                    if (shift_en) begin
                        sr_q  <= full[LONG_PAY-1:0];
                        cnt_q <= cnt_q - CNT_W'(1);
                        if (cnt_q == CNT_W'(1)) begin
                            state_q <= RX_IDLE;
                        end
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    // A body bit count is always loaded before it is counted down.
    assert_cnt_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_BODY) |-> (cnt_q != '0));

endmodule

// File: rtl/dbgp_status_mux.sv
// Builds the outgoing word: a two-bit status code, then either the CPU data
// or the freeze/download flags padded with ones.
// Assumes: it is sampled only when a start bit is accepted.
module dbgp_status_mux
    import dbgp_pkg::*;
#(
    parameter int PAY_W = 30
) (
    input  logic               seq_pend,
    input  logic               dbg_mode,
    input  logic               dl_active,
    input  logic               tx_valid,
    input  logic [PAY_W-1:0]   tx_data,
    input  logic               cpu_irq,
    output dbgp_status_e       status,
    output logic [PAY_W+1:0]   word
);
    // Status priority: error, then data, then interrupt (both debug-only).
    always_comb begin
        if (seq_pend)                  status = ST_SEQERR;
        else if (dbg_mode && tx_valid) status = ST_DATA;
        else if (dbg_mode && cpu_irq)  status = ST_IRQ;
        else                           status = ST_NULL;
    end

    // Word body: data payload, or flags followed by ones.
    always_comb begin
        if (status == ST_DATA) word = {status, tx_data};
        else                   word = {status, dbg_mode, ~dl_active, {(PAY_W-2){1'b1}}};
    end

endmodule

// File: rtl/dbgp_tx_shift.sv
// Transmit shifter: loads the word on the start bit, shifts it out MSB
// first while a frame runs, and shows the inverse of ready when idle.
// Assumes: busy and ready come from the receive side and the top.
module dbgp_tx_shift #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    input  logic              busy,
    input  logic              ready,
    output logic              sdo
);
    logic [WORD_W-1:0] sr_q;

    assign sdo = busy ? sr_q[WORD_W-1] : ~ready;

    // Shift register: load at start, move one bit per strobe in a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= load_word;
        end else if (shift && busy) begin
            sr_q <= {sr_q[WORD_W-2:0], 1'b1};
        end
    end

endmodule

// File: rtl/dbg_serial_port.sv
// Serial debug port top: ready handshake, sequencing-error tracking, the
// CPU data register and delivery of received frames to the CPU.
// Assumes: the tool waits for sdo low before it sends a start bit.
module dbg_serial_port
    import dbgp_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int SHORT_PAY = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_mode,
    input  logic              dl_active,
    input  logic              cpu_irq,
    input  logic              shift_en,
    input  logic              sdi,
    output logic              sdo,
    input  logic              cpu_ir_rd,
    input  logic              cpu_dr_rd,
    input  logic              cpu_dr_wr,
    input  logic [WORD_W-3:0] cpu_dr_wdata,
    output logic [WORD_W-3:0] ir_data,
    output logic              ir_new,
    output logic [WORD_W-3:0] dr_data,
    output logic              dr_new
);
    localparam int LONG_PAY = WORD_W - 2;

    logic                start_acc, busy, last_shift, frame_long, frame_ctrl;
    logic [LONG_PAY-1:0] frame_pay;
    logic                rdy_q, seq_pend_q, seq_out_q, tx_valid_q;
    logic [LONG_PAY-1:0] tx_data_q, ir_data_q, dr_data_q;
    logic                ir_new_q, dr_new_q, rdy_set, deliver;
    dbgp_status_e        status;
    logic [WORD_W-1:0]   word;

    dbgp_frame_rx #(.LONG_PAY(LONG_PAY), .SHORT_PAY(SHORT_PAY)) u_rx (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .sdi(sdi), .ready(rdy_q),
        .start_acc(start_acc), .busy(busy), .last_shift(last_shift),
        .frame_long(frame_long), .frame_ctrl(frame_ctrl), .frame_pay(frame_pay)
    );

    dbgp_status_mux #(.PAY_W(LONG_PAY)) u_mux (
        .seq_pend(seq_pend_q), .dbg_mode(dbg_mode), .dl_active(dl_active),
        .tx_valid(tx_valid_q), .tx_data(tx_data_q), .cpu_irq(cpu_irq),
        .status(status), .word(word)
    );

    dbgp_tx_shift #(.WORD_W(WORD_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(start_acc), .load_word(word),
        .shift(shift_en), .busy(busy), .ready(rdy_q), .sdo(sdo)
    );

    assign rdy_set = dbg_mode ? (cpu_ir_rd || cpu_dr_rd)
                              : (last_shift || (!busy && !start_acc));
    assign deliver = last_shift && !seq_out_q && frame_long && dbg_mode;
    assign ir_data = ir_data_q;
    assign dr_data = dr_data_q;
    assign ir_new  = ir_new_q;
    assign dr_new  = dr_new_q;

    // Ready level: cleared by an accepted start bit, set by the mode rule.
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_q <= 1'b0;
        else        rdy_q <= (rdy_q && !start_acc) || rdy_set;
    end

    // Sequencing error: raised by a long frame outside debug, cleared once sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_pend_q <= 1'b0;
            seq_out_q  <= 1'b0;
        end else begin
            if (start_acc) begin
                seq_out_q <= (status == ST_SEQERR);
                if (status == ST_SEQERR) seq_pend_q <= 1'b0;
            end
            if (last_shift && !seq_out_q && frame_long && !dbg_mode) begin
                seq_pend_q <= 1'b1;
            end
        end
    end

    // CPU-to-tool data register: a write fills it, a data status empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid_q <= 1'b0;
            tx_data_q  <= '0;
        end else if (cpu_dr_wr) begin
            tx_valid_q <= 1'b1;
            tx_data_q  <= cpu_dr_wdata;
        end else if (start_acc && status == ST_DATA) begin
            tx_valid_q <= 1'b0;
        end
    end

    // Frame delivery: a long debug frame goes to the instruction or data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_data_q <= '0;
            dr_data_q <= '0;
            ir_new_q  <= 1'b0;
            dr_new_q  <= 1'b0;
        end else begin
            ir_new_q <= deliver && !frame_ctrl;
            dr_new_q <= deliver && frame_ctrl;
            if (deliver && !frame_ctrl) ir_data_q <= frame_pay;
            if (deliver && frame_ctrl)  dr_data_q <= frame_pay;
        end
    end

    // Reset leaves the port not ready.
    assert_reset_not_ready_R1: assert property (@(posedge clk)
        !rst_n |=> sdo);

    // A frame only begins from the ready state.
    assert_start_needs_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(rdy_q));

    // A pending error outranks every other status.
    assert_error_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_acc && seq_pend_q) |-> (status == ST_SEQERR));

    // Outside debug mode only error or null may be sent.
    assert_trap_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_acc && !dbg_mode) |-> (status == ST_SEQERR || status == ST_NULL));

    // A frame shifted in under an error delivers nothing.
    assert_seq_discard_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (last_shift && seq_out_q) |=> (!ir_new_q && !dr_new_q));

    // In debug mode only a CPU read raises ready.
    assert_dbg_ready_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dbg_mode) && $rose(rdy_q)) |-> $past(cpu_ir_rd || cpu_dr_rd));

    // Delivery pulses last one cycle and never overlap.
    assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_new_q || dr_new_q) |=> (!ir_new_q && !dr_new_q));

endmodule

// File: tb/tb_dbg_serial_port.sv
// Scoreboard bench: the frame task pushes expected sdo bits into a queue,
// and a monitor pops and compares them on each shifted bit.
module tb_dbg_serial_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_mode = 1'b0, dl_active = 1'b0, cpu_irq = 1'b0;
    logic        shift_en = 1'b0, sdi = 1'b0;
    logic        cpu_ir_rd = 1'b0, cpu_dr_rd = 1'b0, cpu_dr_wr = 1'b0;
    logic [29:0] cpu_dr_wdata = '0;
    logic        sdo, ir_new, dr_new;
    logic [29:0] ir_data, dr_data;

    int checks = 0;
    int errors = 0;
    logic cmp_req = 1'b0;
    logic  exp_q[$];
    string tag_q[$];

    bit          m_seq = 1'b0;
    bit          m_txv = 1'b0;
    logic [29:0] m_txd = '0;

    always #4 clk = ~clk;

    dbg_serial_port dut (
        .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .dl_active(dl_active),
        .cpu_irq(cpu_irq), .shift_en(shift_en), .sdi(sdi), .sdo(sdo),
        .cpu_ir_rd(cpu_ir_rd), .cpu_dr_rd(cpu_dr_rd), .cpu_dr_wr(cpu_dr_wr),
        .cpu_dr_wdata(cpu_dr_wdata), .ir_data(ir_data), .ir_new(ir_new),
        .dr_data(dr_data), .dr_new(dr_new)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: compare sdo with the next expected bit on every shifted bit.
    always @(negedge clk) begin
        #1;
        if (cmp_req) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "unexpected bit", {31'd0, sdo}, 32'd0);
            end else begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(sdo === e, t, "sdo bit", {31'd0, sdo}, {31'd0, e});
            end
        end
    end

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    task automatic cpu_write(input logic [29:0] d);
        @(negedge clk); cpu_dr_wr = 1'b1; cpu_dr_wdata = d;
        @(negedge clk); cpu_dr_wr = 1'b0;
        m_txv = 1'b1; m_txd = d;
    endtask

    // Driver: send one frame and queue the word the requirements predict.
    task automatic frame(input bit lng, input bit ctl, input logic [29:0] pay,
                         input string req);
        logic [1:0]  st;
        logic [31:0] w;
        int          nb;
        if (m_seq)                  st = 2'b01;
        else if (dbg_mode && m_txv) st = 2'b00;
        else if (dbg_mode && cpu_irq) st = 2'b10;
        else                        st = 2'b11;
        w  = (st == 2'b00) ? {2'b00, m_txd} : {st, dbg_mode, ~dl_active, 28'hFFFFFFF};
        nb = lng ? 32 : 7;
        exp_q.push_back(1'b0); tag_q.push_back("R2");
        for (int i = 0; i < nb; i++) begin
            exp_q.push_back(w[31-i]); tag_q.push_back(req);
        end
        for (int k = 0; k <= nb; k++) begin
            bit b;
            if (k == 0)      b = 1'b1;
            else if (k == 1) b = lng;
            else if (k == 2) b = ctl;
            else             b = lng ? pay[29-(k-3)] : pay[4-(k-3)];
            @(negedge clk); sdi = b; shift_en = 1'b1; cmp_req = 1'b1;
        end
        @(negedge clk); sdi = 1'b0; shift_en = 1'b0; cmp_req = 1'b0;
        if (st == 2'b00) m_txv = 1'b0;
        if (st == 2'b01) m_seq = 1'b0;
        else if (lng && !dbg_mode) m_seq = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        check(1'b0, "watchdog", "run did not finish", 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(sdo === 1'b1, "R1", "sdo in reset", {31'd0, sdo}, 32'd1);
        check(ir_new === 1'b0 && dr_new === 1'b0, "R1", "pulses in reset",
              {30'd0, ir_new, dr_new}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check(sdo === 1'b0, "R2", "ready after reset", {31'd0, sdo}, 32'd0);

        // Null short frames outside debug; the download flag is active low.
        frame(1'b0, 1'b0, 30'd0, "R5");
        #1 check(sdo === 1'b0, "R2", "ready after transfer", {31'd0, sdo}, 32'd0);
        dl_active = 1'b1;
        frame(1'b0, 1'b0, 30'd0, "R5");
        dl_active = 1'b0;

        // Long frame outside debug: not delivered, error on next transfer.
        frame(1'b1, 1'b0, 30'h1234567, "R9");
        #1 check(ir_new === 1'b0, "R9", "no delivery outside debug", {31'd0, ir_new}, 32'd0);
        frame(1'b0, 1'b0, 30'd0, "R9");

        // Frame under an error is dropped; no second error follows.
        frame(1'b1, 1'b0, 30'h0000111, "R10");
        frame(1'b1, 1'b1, 30'h0000222, "R10");
        frame(1'b0, 1'b0, 30'd0, "R10");

        // Pending data and interrupt stay hidden outside debug.
        cpu_write(30'h2AAAAAAA);
        cpu_irq = 1'b1;
        frame(1'b0, 1'b0, 30'd0, "R8");
        cpu_irq = 1'b0;

        // Debug mode: pending data goes out, the instruction is delivered.
        @(negedge clk); dbg_mode = 1'b1;
        frame(1'b1, 1'b0, 30'h0BADCAFE, "R6");
        #1;
        check(ir_new === 1'b1, "R12", "ir_new pulse", {31'd0, ir_new}, 32'd1);
        check(ir_data === 30'h0BADCAFE, "R12", "ir_data", {2'd0, ir_data}, 32'h0BADCAFE);
        check(sdo === 1'b1, "R11", "not ready after debug frame", {31'd0, sdo}, 32'd1);
        cpu_write(30'h15555555);
        #1 check(sdo === 1'b1, "R11", "write leaves not ready", {31'd0, sdo}, 32'd1);
        pulse(cpu_ir_rd);
        #1 check(sdo === 1'b0, "R11", "read raises ready", {31'd0, sdo}, 32'd0);

        // Short debug frame: only the top of the data goes out.
        frame(1'b0, 1'b0, 30'd0, "R7");

        // Start bits while not ready are ignored.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); sdi = 1'b1; shift_en = 1'b1;
            #1 check(sdo === 1'b1, "R3", "ignored start", {31'd0, sdo}, 32'd1);
        end
        @(negedge clk); sdi = 1'b0; shift_en = 1'b0;

        // Interrupt status with flags; a data frame is delivered.
        cpu_irq = 1'b1;
        pulse(cpu_dr_rd);
        frame(1'b1, 1'b1, 30'h03C3C3C3, "R4");
        #1;
        check(dr_new === 1'b1, "R12", "dr_new pulse", {31'd0, dr_new}, 32'd1);
        check(dr_data === 30'h03C3C3C3, "R12", "dr_data", {2'd0, dr_data}, 32'h03C3C3C3);
        check(ir_new === 1'b0, "R12", "no ir_new on data frame", {31'd0, ir_new}, 32'd0);
        cpu_irq = 1'b0;

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule